// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Bit-Slip Alignment

The block turns one serial bit stream into 8-bit parallel words at single data rate. Each rising edge of a fast bit clock samples one bit. A word clock runs at one eighth of that rate, and its rising edges line up with every eighth rising edge of the bit clock. A word is presented once per word-clock cycle, with the bit received first on the most significant output bit.

At power-up the word boundary sits at an arbitrary place in the stream. A controller outside the block pulses the slip input to move the boundary one bit at a time until a known training byte appears on the output.

After an accepted slip the block needs two word-clock cycles to settle. During that time a ready flag is low and further slip requests are ignored. The flag is also low while reset is applied and for two word-clock cycles after reset is released.

Top module: `serial_word_deser`

## Requirements
- R1: One serial bit is taken on each rising edge of `fast_clk`, and a new 8-bit `word_q` is registered on each rising edge of `word_clk`.
- R2: Bit ordering and latency. Number the fast edges so that fast edge 8j coincides with word edge j, and let k be the slip position. After word edge j, `word_q[7]` holds the bit sampled at fast edge 8j-16-k and `word_q[0]` holds the bit sampled at fast edge 8j-9-k. For a repeating byte stream, the word with k = 0 is that byte rotated left by the stream's bit offset modulo 8.
- R3: `slip_req` is sampled on `word_clk`. A slip is accepted when `slip_req` is high at an edge where `word_ok` is high. Each accepted slip increases k by one, so the output word moves one bit earlier in the stream.
- R4: Eight accepted slips bring the word boundary back to its starting alignment, because k counts modulo 8.
- R5: A `slip_req` seen at a word edge while `word_ok` is low is ignored. Holding `slip_req` high for three word cycles therefore produces exactly one slip.
- R6: `word_ok` goes low at the edge that accepts a slip. It stays low at the next edge and goes high at the second edge after the slip.
- R7: After reset is released, `word_ok` is low after the first word edge and high from the second. Slip requests made during those two edges are ignored.
- R8: Reset is active high and asynchronous. It sets `word_q` to 0 and `word_ok` to 0 at once, without waiting for a clock edge, and it returns k to 0. Reset should be held for at least two word-clock cycles.
- R9: Suppose the input repeats byte 0xBC (or any byte whose eight rotations are all different) with a bit offset s. Slipping from reset until that byte appears takes exactly s mod 8 slips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Bit clock; samples one serial bit per rising edge |
| word_clk | input | 1 | Word clock, one eighth of the bit rate, rising edges aligned with fast_clk |
| rst | input | 1 | Asynchronous active-high reset |
| ser_in | input | 1 | Serial data input |
| slip_req | input | 1 | Request to move the word boundary by one bit, sampled on word_clk |
| word_q | output | 8 | Parallel word, earliest bit in bit 7 |
| word_ok | output | 1 | High when the slip position has settled and word_q can be used |

## Verification
The assertions assume that the word clock's rising edges fall exactly on fast-clock rising edges, and that `slip_req` changes only between word-clock edges. The bench generates both clocks from one time base, with the word-clock edges placed on every eighth fast edge. It drives `ser_in` on the falling edge of the fast clock and `slip_req` on the falling edge of the word clock. Reset is always held for three word cycles, longer than the two-cycle minimum.

// File: rtl/deser_pkg.sv
package deser_pkg;

    localparam int unsigned DFLT_WORD_W  = 8;
    localparam int unsigned DFLT_SETTLE  = 2;

    // Width of a field able to index 0..n-1 (at least one bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // History needed so every boundary offset 0..w-1 sees a full word
    function automatic int unsigned hist_width(input int unsigned w);
        return 2 * w - 1;
    endfunction

    // Slip position advance with wrap at the word width
    function automatic int unsigned wrap_inc(input int unsigned pos, input int unsigned n);
        return (pos + 1 >= n) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/deser_bit_shift.sv
module deser_bit_shift #(
    parameter int unsigned HIST_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    output logic [HIST_W-1:0] hist
);

    // Newest bit enters at index 0, older bits move up
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {hist[HIST_W-2:0], din};
        end
    end

endmodule

// File: rtl/deser_slip_ctrl.sv
module deser_slip_ctrl #(
    parameter int unsigned WORD_W     = deser_pkg::DFLT_WORD_W,
    parameter int unsigned SETTLE_CYC = deser_pkg::DFLT_SETTLE,
    parameter int unsigned POS_W      = deser_pkg::idx_width(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slip_req,
    output logic [POS_W-1:0] pos,
    output logic             ok
);

    localparam int unsigned CNT_W = deser_pkg::idx_width(SETTLE_CYC + 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] wait_cnt;
        logic             ok;
    } slip_state_t;

    slip_state_t st_q, st_d;
    logic        accept;

    always_comb begin
        st_d   = st_q;
        accept = slip_req && (st_q.wait_cnt == '0);
        if (accept) begin
            st_d.pos      = POS_W'(deser_pkg::wrap_inc(int'(st_q.pos), WORD_W));
            st_d.wait_cnt = CNT_W'(SETTLE_CYC);
            st_d.ok       = 1'b0;
        end else if (st_q.wait_cnt != '0) begin
            st_d.wait_cnt = st_q.wait_cnt - 1'b1;
            st_d.ok       = (st_q.wait_cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.pos      <= '0;
            st_q.wait_cnt <= CNT_W'(SETTLE_CYC);
            st_q.ok       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos = st_q.pos;
    assign ok  = st_q.ok;

endmodule

// File: rtl/deser_word_pick.sv
module deser_word_pick #(
    parameter int unsigned WORD_W = deser_pkg::DFLT_WORD_W,
    parameter int unsigned HIST_W = deser_pkg::hist_width(WORD_W),
    parameter int unsigned POS_W  = deser_pkg::idx_width(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HIST_W-1:0] hist,
    input  logic [POS_W-1:0]  pos,
    output logic [WORD_W-1:0] word
);

    logic [HIST_W-1:0] snap;
    logic [WORD_W-1:0] cand [WORD_W];

    // Snapshot of the bit history taken once per word
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            snap <= '0;
        end else begin
            snap <= hist;
        end
    end

    // One candidate window per boundary offset
    for (genvar i = 0; i < WORD_W; i++) begin : g_win
        assign cand[i] = snap[i +: WORD_W];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            word <= '0;
        end else begin
            word <= cand[pos];
        end
    end

endmodule

// File: rtl/serial_word_deser.sv
module serial_word_deser #(
    parameter int unsigned WORD_W     = deser_pkg::DFLT_WORD_W,
    parameter int unsigned SETTLE_CYC = deser_pkg::DFLT_SETTLE
) (
    input  logic              fast_clk,
    input  logic              word_clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              slip_req,
    output logic [WORD_W-1:0] word_q,
    output logic              word_ok
);

    localparam int unsigned HIST_W = deser_pkg::hist_width(WORD_W);
    localparam int unsigned POS_W  = deser_pkg::idx_width(WORD_W);

    logic [HIST_W-1:0] bit_hist;
    logic [POS_W-1:0]  slip_pos;

    deser_bit_shift #(
        .HIST_W(HIST_W)
    ) u_shift (
        .clk  (fast_clk),
        .rst  (rst),
        .din  (ser_in),
        .hist (bit_hist)
    );

    deser_slip_ctrl #(
        .WORD_W    (WORD_W),
        .SETTLE_CYC(SETTLE_CYC),
        .POS_W     (POS_W)
    ) u_slip (
        .clk      (word_clk),
        .rst      (rst),
        .slip_req (slip_req),
        .pos      (slip_pos),
        .ok       (word_ok)
    );

    deser_word_pick #(
        .WORD_W(WORD_W),
        .HIST_W(HIST_W),
        .POS_W (POS_W)
    ) u_pick (
        .clk  (word_clk),
        .rst  (rst),
        .hist (bit_hist),
        .pos  (slip_pos),
        .word (word_q)
    );

endmodule

// File: rtl/deser_checker.sv
module deser_checker #(
    parameter int unsigned WORD_W = deser_pkg::DFLT_WORD_W
) (
    input logic                                      word_clk,
    input logic                                      rst,
    input logic                                      slip_req,
    input logic                                      word_ok,
    input logic [deser_pkg::idx_width(WORD_W)-1:0]   slip_pos
);

    localparam int unsigned POS_W = deser_pkg::idx_width(WORD_W);

    AST_SLIP_STEPS_ONE: assert property (@(posedge word_clk) disable iff (rst)
        (slip_req && word_ok) |=> (slip_pos == POS_W'((int'($past(slip_pos)) + 1) % WORD_W))); // R3

    AST_SLIP_IGNORED_WHILE_SETTLING: assert property (@(posedge word_clk) disable iff (rst)
        (!word_ok) |=> $stable(slip_pos)); // R5

    AST_OK_DROPS_ON_SLIP: assert property (@(posedge word_clk) disable iff (rst)
        (slip_req && word_ok) |=> !word_ok); // R6

    AST_OK_LOW_TWO_EDGES: assert property (@(posedge word_clk) disable iff (rst)
        $fell(word_ok) |=> !word_ok); // R6

    AST_OK_RISE_AFTER_SETTLE: assert property (@(posedge word_clk) disable iff (rst)
        $rose(word_ok) |-> !$past(word_ok, 2)); // R7

endmodule

bind serial_word_deser deser_checker #(
    .WORD_W(WORD_W)
) u_chk (
    .word_clk (word_clk),
    .rst      (rst),
    .slip_req (slip_req),
    .word_ok  (word_ok),
    .slip_pos (slip_pos)
);

// File: tb/serial_word_deser_test.sv
module serial_word_deser_test;

    logic       fast_clk = 1'b0;
    logic       word_clk = 1'b0;
    logic       rst      = 1'b0;
    logic       ser_in   = 1'b0;
    logic       slip_req = 1'b0;
    logic [7:0] word_q;
    logic       word_ok;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] pat_byte = 8'hBC;
    int pat_off = 5;
    int e_cnt   = 0;

    // Training table: {byte, bit offset}; expected slips = offset mod 8
    localparam logic [15:0] TRAIN_TBL [0:5] = '{
        16'hBC00, 16'hBC05, 16'hBC0D, 16'h3503, 16'h0107, 16'hBC08
    };

    serial_word_deser uut (
        .fast_clk (fast_clk),
        .word_clk (word_clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .slip_req (slip_req),
        .word_q   (word_q),
        .word_ok  (word_ok)
    );

    // 100 MHz bit clock, word clock rising on every eighth bit-clock rise
    initial forever #5 fast_clk = ~fast_clk;
    initial begin
        #5;
        forever begin
            word_clk = 1'b1;
            #40;
            word_clk = 1'b0;
            #40;
        end
    end

    // Serial stream: bit for fast edge e is pat_byte[7 - ((e + pat_off) mod 8)]
    always @(negedge fast_clk) begin
        ser_in = pat_byte[7 - ((e_cnt + 1 + pat_off) % 8)];
        e_cnt  = e_cnt + 1;
    end

    function automatic logic [7:0] rol8(input logic [7:0] b, input int r);
        logic [15:0] t;
        t = {b, b} << r;
        return t[15:8];
    endfunction

    function automatic int mod8(input int v);
        return ((v % 8) + 8) % 8;
    endfunction

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        n_cmp++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ok();
        for (int i = 0; i < 20 && !word_ok; i++) @(negedge word_clk);
    endtask

    task automatic settle_full();
        wait_ok();
        repeat (2) @(negedge word_clk);
    endtask

    task automatic pulse_slip();
        @(negedge word_clk);
        slip_req = 1'b1;
        @(negedge word_clk);
        slip_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge word_clk);
        rst = 1'b1;
        repeat (3) @(negedge word_clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        int slips;
        #1 rst = 1'b1;
        repeat (3) @(negedge word_clk);
        // R8: reset state
        chk(word_q == 8'h00, "R8 reset word", word_q, 0);
        chk(word_ok == 1'b0, "R8 reset ok", word_ok, 0);

        // R7: release with slip held over both settling edges
        rst = 1'b0;
        slip_req = 1'b1;
        @(negedge word_clk);
        chk(word_ok == 1'b0, "R7 ok after first edge", word_ok, 0);
        @(negedge word_clk);
        slip_req = 1'b0;
        chk(word_ok == 1'b1, "R7 ok after second edge", word_ok, 1);
        repeat (2) @(negedge word_clk);
        chk(word_q == rol8(8'hBC, 5), "R7 slip ignored after reset", word_q, rol8(8'hBC, 5));

        // R9: training table walked by one loop
        for (int t = 0; t < 6; t++) begin
            pat_byte = TRAIN_TBL[t][15:8];
            pat_off  = int'(TRAIN_TBL[t][7:0]);
            do_reset();
            settle_full();
            slips = 0;
            while (word_q != pat_byte && slips < 16) begin
                pulse_slip();
                wait_ok();
                slips++;
            end
            chk(slips == pat_off % 8, "R9 slips to lock", slips, pat_off % 8);
            chk(word_q == pat_byte, "R9 locked word", word_q, pat_byte);
        end

        // R1/R2: bit ordering with no slip
        pat_byte = 8'h35;
        pat_off  = 0;
        do_reset();
        settle_full();
        for (int i = 0; i < 4; i++) begin
            chk(word_q == 8'h35, "R1 consecutive words", word_q, 8'h35);
            @(negedge word_clk);
        end
        pat_off = 2;
        do_reset();
        settle_full();
        chk(word_q == rol8(8'h35, 2), "R2 offset word", word_q, rol8(8'h35, 2));

        // R3/R6: single slip and its settling window
        pat_byte = 8'hBC;
        pat_off  = 5;
        do_reset();
        settle_full();
        pulse_slip();
        chk(word_ok == 1'b0, "R6 ok low at slip edge", word_ok, 0);
        @(negedge word_clk);
        chk(word_ok == 1'b0, "R6 ok low one edge later", word_ok, 0);
        @(negedge word_clk);
        chk(word_ok == 1'b1, "R6 ok high two edges later", word_ok, 1);
        chk(word_q == rol8(8'hBC, 4), "R3 one slip", word_q, rol8(8'hBC, 4));

        // R5: slip held three cycles gives exactly one slip (k = 2)
        @(negedge word_clk);
        slip_req = 1'b1;
        repeat (3) @(negedge word_clk);
        slip_req = 1'b0;
        settle_full();
        chk(word_q == rol8(8'hBC, 3), "R5 held request", word_q, rol8(8'hBC, 3));

        // R4: eight slips return to the same alignment
        for (int i = 0; i < 8; i++) begin
            pulse_slip();
            wait_ok();
            if (i == 3) begin
                chk(word_q == rol8(8'hBC, mod8(5 - 6)), "R3 four more slips", word_q, rol8(8'hBC, mod8(5 - 6)));
            end
        end
        settle_full();
        chk(word_q == rol8(8'hBC, 3), "R4 eight slips wrap", word_q, rol8(8'hBC, 3));

        // R8: asynchronous reset between clock edges, slip position cleared
        @(negedge word_clk);
        #13;
        rst = 1'b1;
        #2;
        chk(word_q == 8'h00, "R8 async word clear", word_q, 0);
        chk(word_ok == 1'b0, "R8 async ok clear", word_ok, 0);
        repeat (3) @(negedge word_clk);
        rst = 1'b0;
        settle_full();
        chk(word_q == rol8(8'hBC, 5), "R8 slip position cleared", word_q, rol8(8'hBC, 5));

        finish_run();
    end

endmodule